// File: doc/BRIEF.md
# I2C Register-File Target with Auto-Increment

This block is a 7-bit-addressed target on a two-wire I2C bus. It gives a bus controller access to a small bank of byte registers. Both bus lines are sampled by the system clock through synchronizers. From the sampled lines the block finds start, repeated-start and stop conditions. It compares the address byte with a device address taken from an input port.

In a write transaction the first data byte loads an internal register pointer, and every later byte is stored at the pointer. A read transaction returns bytes starting at the current pointer, so a controller can read a register in three steps: write the pointer, issue a repeated start, then read. The pointer moves forward by one after every byte that is stored or sent, and it wraps at the end of the bank. The block also accepts the general-call address when that acceptance is enabled.

The top register of the bank is a status byte. Its bit 0 is a data-ready flag that the surrounding logic sets with a pulse. An interrupt line follows the flag. Reading the status byte over the bus clears the flag. After each acknowledge slot the block can hold the clock line low for a fixed number of cycles, so that the controller waits.

Top module: `i2c_reg_target`

## Requirements
- R1: When SDA falls while SCL is high, a transaction begins. When SDA rises while SCL is high, the transaction ends and the block releases SDA. After reset, SDA, SCL and irq are all released or low.
- R2: The address byte is taken MSB first on rising SCL edges. Its upper seven bits are compared with `dev_addr`, and its bit 0 selects read (1) or write (0). On a match the block pulls SDA low during the ninth clock. On a mismatch it never drives SDA, and it ignores the rest of the transaction.
- R3: In a write transaction, the first data byte loads the pointer from its low log2(REG_COUNT) bits. Each later byte is stored at the pointer. The block acknowledges every byte.
- R4: The pointer goes up by one after every stored or transmitted byte. From index REG_COUNT-1 it wraps to 0.
- R5: A read after a repeated start returns bytes MSB first, starting at the pointer that was set before the repeated start. SDA changes only while SCL is low.
- R6: When the controller acknowledges, the block sends the next byte. When it does not acknowledge, the block releases SDA and ignores the bus until the next start or stop. The pointer then rests just past the last byte sent.
- R7: Address 0000000 with the write bit is acknowledged and handled as a normal write when `gc_enable` is 1. When `gc_enable` is 0 it is neither acknowledged nor stored.
- R8: Index REG_COUNT-1 reads as {7'b0, ready}. A one-cycle pulse on `ready_set` sets ready, and `irq` is high while ready is set. Bus writes to this index are acknowledged but change nothing.
- R9: Sending the status byte on the bus clears ready, so `irq` falls. If `ready_set` pulses in that same cycle, ready stays set.
- R10: After each ninth clock that the block acknowledges, and after each acknowledge from the controller in a read, the block drives `scl_oe` high for STRETCH_CYC clock cycles. A value of 0 turns this off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both bus lines are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_addr | input | 7 | Device address this target answers to |
| gc_enable | input | 1 | 1 = accept general-call writes |
| ready_set | input | 1 | One-cycle pulse that sets the data-ready flag |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 = pull SCL low (clock hold) |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge or data 0) |
| irq | output | 1 | High while the data-ready flag is set |

## Verification
The bench targets the pointer across a repeated start. A design that reset the pointer on a start, or advanced it twice per byte, would return the wrong register after the restart. Wrap-around is tested through the status slot: a write aimed at index REG_COUNT-1 must leave the flag untouched and land the next byte at index 0. A design that stored into the status byte or wrapped late would read back wrong values. The bench also checks the general-call gate, a foreign address and the flag clear-on-read with the following re-read. Any of these, done wrong, would show up as a stray acknowledge, a stored byte or a stuck `irq`. A monitor on every clock catches SDA moving while SCL is high, and the measured clock hold shows a stretch that is missing or of the wrong length.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  // Link-layer states of the target
  typedef enum logic [2:0] {
    LS_IDLE,
    LS_ADDR,
    LS_ACKA,
    LS_RX,
    LS_ACKD,
    LS_TX,
    LS_MACK,
    LS_WAIT
  } link_state_e;

endpackage

// File: rtl/i2c_reg_sync.sv
module i2c_reg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA edges seen while SCL stays high are bus conditions
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_reg_stretch.sv
module i2c_reg_stretch #(
  parameter int HOLD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic scl_oe
);

  if (HOLD_CYC == 0) begin : g_none
    logic unused_ins;
    assign unused_ins = go ^ clk ^ rst_n;
    assign scl_oe     = 1'b0;
  end else begin : g_hold
    localparam int SW = $clog2(HOLD_CYC + 1);
    logic [SW-1:0] cnt_q;
    logic [SW-1:0] cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      if (go) begin
        cnt_d = SW'(HOLD_CYC);
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - SW'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_d;
      end
    end

    assign scl_oe = (cnt_q != '0);
  end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int REG_COUNT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic       wr_is_ptr,
  input  logic [7:0] wr_data,
  input  logic       rd_req,
  input  logic       ready_set,
  output logic [7:0] rd_data,
  output logic       ready
);

  localparam int PW       = $clog2(REG_COUNT);
  localparam int STAT_IDX = REG_COUNT - 1;

  logic [7:0]          store [STAT_IDX];
  logic [STAT_IDX-1:0] wr_hit;
  logic [PW-1:0]       ptr_q;
  logic [PW-1:0]       ptr_d;
  logic                rdy_q;
  logic                rdy_d;
  logic                at_status;

  assign at_status = (ptr_q == PW'(STAT_IDX));

  always_comb begin
    ptr_d = ptr_q;
    if (wr_stb) begin
      ptr_d = wr_is_ptr ? wr_data[PW-1:0] : ptr_q + PW'(1);
    end else if (rd_req) begin
      ptr_d = ptr_q + PW'(1);
    end
  end

  always_comb begin
    rdy_d = rdy_q;
    if (rd_req && at_status) begin
      rdy_d = 1'b0;
    end
    if (ready_set) begin
      rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      rdy_q <= rdy_d;
    end
  end

  for (genvar g = 0; g < STAT_IDX; g++) begin : g_reg
    assign wr_hit[g] = wr_stb & ~wr_is_ptr & (ptr_q == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store[g] <= '0;
      end else if (wr_hit[g]) begin
        store[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = {7'b0, rdy_q};
    for (int i = 0; i < STAT_IDX; i++) begin
      if (ptr_q == PW'(i)) begin
        rd_data = store[i];
      end
    end
  end

  assign ready = rdy_q;

endmodule

// File: rtl/i2c_reg_link.sv
module i2c_reg_link
  import i2c_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] dev_addr,
  input  logic       gc_enable,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic       wr_is_ptr,
  output logic [7:0] wr_data,
  output logic       rd_req,
  output logic       stretch_go
);

  link_state_e state_q, state_d;
  logic [3:0]  cnt_q, cnt_d;
  logic [7:0]  sh_q, sh_d;
  logic        rw_q, rw_d;
  logic        ptr_ph_q, ptr_ph_d;
  logic        mack_q, mack_d;
  logic        oe_q, oe_d;
  logic        addr_hit;

  assign addr_hit = (sh_q[7:1] == dev_addr) ||
                    ((sh_q[7:1] == 7'd0) && !sh_q[0] && gc_enable);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    rw_d       = rw_q;
    ptr_ph_d   = ptr_ph_q;
    mack_d     = mack_q;
    oe_d       = oe_q;
    wr_stb     = 1'b0;
    rd_req     = 1'b0;
    stretch_go = 1'b0;
    if (stop_det) begin
      state_d = LS_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = LS_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        LS_ADDR: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (addr_hit) begin
              state_d = LS_ACKA;
              oe_d    = 1'b1;
              rw_d    = sh_q[0];
            end else begin
              state_d = LS_WAIT;
            end
          end
        end
        LS_ACKA: begin
          if (scl_fall) begin
            stretch_go = 1'b1;
            cnt_d      = '0;
            if (rw_q) begin
              rd_req  = 1'b1;
              sh_d    = rd_data;
              oe_d    = ~rd_data[7];
              state_d = LS_TX;
            end else begin
              oe_d     = 1'b0;
              ptr_ph_d = 1'b1;
              state_d  = LS_RX;
            end
          end
        end
        LS_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            wr_stb   = 1'b1;
            ptr_ph_d = 1'b0;
            oe_d     = 1'b1;
            state_d  = LS_ACKD;
          end
        end
        LS_ACKD: begin
          if (scl_fall) begin
            stretch_go = 1'b1;
            oe_d       = 1'b0;
            cnt_d      = '0;
            state_d    = LS_RX;
          end
        end
        LS_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            oe_d    = 1'b0;
            state_d = LS_MACK;
          end else if (scl_fall && cnt_q != 4'd0) begin
            sh_d = {sh_q[6:0], 1'b0};
            oe_d = ~sh_q[6];
          end
        end
        LS_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              rd_req     = 1'b1;
              stretch_go = 1'b1;
              sh_d       = rd_data;
              oe_d       = ~rd_data[7];
              cnt_d      = '0;
              state_d    = LS_TX;
            end else begin
              state_d = LS_WAIT;
            end
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LS_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      rw_q     <= 1'b0;
      ptr_ph_q <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      rw_q     <= rw_d;
      ptr_ph_q <= ptr_ph_d;
      mack_q   <= mack_d;
      oe_q     <= oe_d;
    end
  end

  assign sda_oe    = oe_q;
  assign wr_data   = sh_q;
  assign wr_is_ptr = ptr_ph_q;

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int REG_COUNT   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] dev_addr,
  input  logic       gc_enable,
  input  logic       ready_set,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       irq
);

  logic [1:0] rst_pipe;
  logic       rst_q_n;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_stb, wr_is_ptr, rd_req, stretch_go, ready;
  logic [7:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe[1];

  i2c_reg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_reg_link u_link (
    .clk(clk), .rst_n(rst_q_n), .dev_addr(dev_addr), .gc_enable(gc_enable),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_is_ptr(wr_is_ptr),
    .wr_data(wr_data), .rd_req(rd_req), .stretch_go(stretch_go)
  );

  i2c_reg_bank #(.REG_COUNT(REG_COUNT)) u_bank (
    .clk(clk), .rst_n(rst_q_n), .wr_stb(wr_stb), .wr_is_ptr(wr_is_ptr),
    .wr_data(wr_data), .rd_req(rd_req), .ready_set(ready_set),
    .rd_data(rd_data), .ready(ready)
  );

  i2c_reg_stretch #(.HOLD_CYC(STRETCH_CYC)) u_stretch (
    .clk(clk), .rst_n(rst_q_n), .go(stretch_go), .scl_oe(scl_oe)
  );

  assign irq = ready;

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int STRETCH_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic scl_oe,
  input logic stop_det,
  input logic ready_set,
  input logic rd_req,
  input logic irq
);

  logic [15:0] hold_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_run <= '0;
    end else if (scl_oe) begin
      if (hold_run != 16'hFFFF) hold_run <= hold_run + 16'd1;
    end else begin
      hold_run <= '0;
    end
  end

  // R5: SDA drive changes only while sampled SCL is low
  p_sda_moves_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R1: bus released after a stop
  p_release_on_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R8: a set pulse raises the interrupt
  p_irq_on_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_set |=> irq);

  // R9: the interrupt drops only after a byte was fetched for the bus
  p_irq_drop_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(rd_req));

  // R10: clock hold never exceeds its configured length
  p_hold_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> (hold_run < 16'(STRETCH_CYC)));

endmodule

bind i2c_reg_target i2c_reg_target_chk #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .scl_oe(scl_oe), .stop_det(stop_det), .ready_set(ready_set),
  .rd_req(rd_req), .irq(irq)
);

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;

  localparam int NREG = 16;
  localparam int HOLD = 40;
  localparam int Q    = 20;
  localparam logic [6:0] MY_ADDR = 7'h5A;

  logic clk, rst_n, gc_enable, ready_set;
  logic scl_m, sda_m;
  logic scl_oe, sda_oe, irq;
  wire  scl_bus = scl_m & ~scl_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int fails  = 0;
  int last_hold = 0;
  int first_hold = 0;
  int edge_viol = 0;
  logic [7:0] model [NREG];
  logic model_rdy = 1'b0;

  i2c_reg_target #(.REG_COUNT(NREG), .SYNC_STAGES(2), .STRETCH_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .dev_addr(MY_ADDR), .gc_enable(gc_enable),
    .ready_set(ready_set), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Per-clock monitor: the target's SDA drive may not move while SCL is high (R5)
  logic oe_prev = 1'b0;
  logic scl_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((sda_oe != oe_prev) && scl_bus && scl_prev) edge_viol++;
    end
    oe_prev  = sda_oe;
    scl_prev = scl_bus;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_high();
    int h = 0;
    scl_m = 1'b1;
    @(negedge clk);
    while (!scl_bus) begin
      h++;
      @(negedge clk);
    end
    last_hold = h;
    wait_q();
  endtask

  task automatic bus_start();
    sda_m = 1'b1;
    wait_q();
    scl_high();
    sda_m = 1'b0;
    wait_q();
    scl_m = 1'b0;
    wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    wait_q();
    scl_high();
    sda_m = 1'b1;
    wait_q();
  endtask

  task automatic mwrite(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      scl_high();
      if (i == 7) first_hold = last_hold;
      scl_m = 1'b0;
      wait_q();
    end
    sda_m = 1'b1;
    wait_q();
    scl_high();
    ack = ~sda_bus;
    scl_m = 1'b0;
    wait_q();
  endtask

  task automatic mread(input logic give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      wait_q();
      scl_high();
      d = {d[6:0], sda_bus};
      scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    wait_q();
    scl_high();
    scl_m = 1'b0;
    wait_q();
    sda_m = 1'b1;
  endtask

  // Write pointer then restart and read n bytes, checking each against the model
  task automatic read_from(input int p, input int n, input string req);
    logic a;
    logic [7:0] d;
    bus_start();
    mwrite({MY_ADDR, 1'b0}, a);
    mwrite(8'(p), a);
    bus_start();
    mwrite({MY_ADDR, 1'b1}, a);
    chk({req, " read address ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      mread(k != n - 1, d);
      if (((p + k) % NREG) == NREG - 1) chk({req, " status byte"}, d, {7'b0, model_rdy});
      else chk({req, " read data"}, d, model[(p + k) % NREG]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    rst_n = 1'b0; gc_enable = 1'b0; ready_set = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Reset state
    chk("R1 sda released after reset", sda_oe, 0);
    chk("R10 scl released after reset", scl_oe, 0);
    chk("R8 irq low after reset", irq, 0);

    // Pointer setup plus three stored bytes
    bus_start();
    mwrite({MY_ADDR, 1'b0}, a);
    chk("R2 own address acknowledged", a, 1);
    mwrite(8'h03, a);
    chk("R3 pointer byte acknowledged", a, 1);
    chk("R10 hold after address ack", int'(first_hold >= HOLD - Q && first_hold <= HOLD - Q + 4), 1);
    if (!(first_hold >= HOLD - Q && first_hold <= HOLD - Q + 4))
      $display("FAIL R10 hold length actual=%0d expected=%0d..%0d", first_hold, HOLD - Q, HOLD - Q + 4);
    mwrite(8'hA5, a); chk("R3 data ack", a, 1);
    mwrite(8'h3C, a); chk("R3 data ack", a, 1);
    mwrite(8'h77, a); chk("R3 data ack", a, 1);
    model[3] = 8'hA5; model[4] = 8'h3C; model[5] = 8'h77;
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R1 sda released after stop", sda_oe, 0);

    // Repeated-start read of two bytes, NACK on the last
    bus_start();
    mwrite({MY_ADDR, 1'b0}, a);
    mwrite(8'h03, a);
    bus_start();
    mwrite({MY_ADDR, 1'b1}, a);
    chk("R2 read address ack", a, 1);
    mread(1'b1, d); chk("R5 first byte from pointer", d, 8'hA5);
    mread(1'b0, d); chk("R6 next byte after ACK", d, 8'h3C);
    repeat (Q) @(negedge clk);
    chk("R6 sda released after NACK", sda_oe, 0);
    bus_stop();

    // Plain read continues where the last one stopped
    bus_start();
    mwrite({MY_ADDR, 1'b1}, a);
    mread(1'b0, d);
    chk("R4 pointer advanced past read bytes", d, 8'h77);
    bus_stop();

    // Foreign address: no ack, nothing stored
    bus_start();
    mwrite({MY_ADDR ^ 7'h01, 1'b0}, a);
    chk("R2 foreign address not acked", a, 0);
    mwrite(8'h06, a);
    mwrite(8'hEE, a);
    chk("R2 no ack inside foreign transaction", a, 0);
    bus_stop();
    read_from(6, 1, "R2 foreign write not stored");

    // Wrap through the status slot; upper pointer bits dropped
    bus_start();
    mwrite({MY_ADDR, 1'b0}, a);
    mwrite(8'h1E, a);
    mwrite(8'h11, a);
    mwrite(8'h22, a); chk("R8 write to status acked", a, 1);
    mwrite(8'h33, a);
    model[14] = 8'h11; model[0] = 8'h33;
    bus_stop();
    read_from(14, 3, "R4 wrap and R8 status untouched");

    // General call gated off, then on
    bus_start();
    mwrite(8'h00, a);
    chk("R7 general call ignored when disabled", a, 0);
    mwrite(8'h09, a);
    mwrite(8'h99, a);
    bus_stop();
    gc_enable = 1'b1;
    bus_start();
    mwrite(8'h00, a);
    chk("R7 general call acked when enabled", a, 1);
    mwrite(8'h08, a);
    mwrite(8'h5C, a);
    chk("R7 general call data acked", a, 1);
    model[8] = 8'h5C;
    bus_stop();
    read_from(8, 2, "R7 general call stored");

    // Data-ready flag, interrupt and clear-on-read
    @(negedge clk); ready_set = 1'b1;
    @(negedge clk); ready_set = 1'b0;
    model_rdy = 1'b1;
    @(negedge clk);
    chk("R8 irq raised by set pulse", irq, 1);
    read_from(15, 1, "R9 status reads ready");
    model_rdy = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 irq cleared by status read", irq, 0);
    read_from(15, 1, "R9 status reads clear");

    chk("R5 sda never moved while scl high", edge_viol, 0);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule